// File: doc/BRIEF.md
# Second-Level Interrupt Aggregator with Forward Bypass

This block sits between a set of peripheral interrupt lines and a parent interrupt controller. Up to 32 level-sensitive lines come in. Each line that is wired to a real source is captured into a status word. Software masks lines through an enable word. The block drives a small number of grouped parent outputs. Each grouped output is the OR of the lines that are pending, enabled and selected by that output's mapping mask. A separate wake output ORs every pending, enabled line that belongs to the grouped logic, so the controller can serve as a wakeup source.

Some lines, typically from serial ports, pass through a forward gate. When the forward mask marks a line, its level goes straight to a parent output of its own, whatever the enable word holds, and it never reaches the grouped outputs or the wake output. The set of connected lines, the forward mask and the mapping masks are fixed for each instance by parameters. There are no bit-set or bit-clear registers. To change one enable bit, software reads the whole enable word, modifies it and writes it back.

Access uses a request/response register port. A request is a one-cycle `req_valid` pulse. The port applies no back-pressure and accepts every request in the cycle it is presented. A read answers exactly one cycle later with `rsp_valid` and the data. The response has no ready signal, so the requester must take it in that cycle. A write produces no response.

Top module: `irq_l2_aggregator`

## Requirements
- R1: After reset the enable word reads 0, every grouped output and the wake output are 0, and `rsp_valid` is 0.
- R2: A write to offset 0x0 replaces the whole enable word. Only connected bit positions are stored, and unconnected positions read back as 0. A read of offset 0x0 returns the stored word, so a read-modify-write sequence sets exactly the bits intended.
- R3: A read of offset 0x4 returns the status word. That word equals the input lines ANDed with the connected-line mask, forwarded lines included, as sampled on the previous clock edge. A write to offset 0x4 has no effect.
- R4: Any other offset reads as 0, and a write to it leaves the enable word unchanged.
- R5: Grouped output g goes to 1 one clock after (line level AND enable AND mapping mask g AND NOT forward mask AND connected mask) becomes non-zero, and goes back to 0 one clock after that value becomes zero. Default masks: group 0 = 0x00000EB8, group 1 = 0x00000140.
- R6: Forward output k carries the registered level of the k-th set bit of the forward mask, counted upward from bit 0, one clock after the input, regardless of the enable word. Default forward mask 0x00000007, so lines 0, 1 and 2 map to outputs 0, 1 and 2.
- R7: A forwarded line never asserts a grouped output or the wake output, even when its enable bit is set.
- R8: The wake output is the OR over all connected, non-forwarded lines of (level AND enable), registered with one clock of latency.
- R9: A line outside the connected mask (default 0x00000FFF) never asserts any output and always reads as 0 in the status and enable words.
- R10: `rsp_valid` is 1 exactly in the cycle after a read request and 0 after a write or an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Level-sensitive peripheral interrupt lines |
| req_valid | input | 1 | Register request present, always accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the request |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| grp_irq | output | N_GRP | Grouped parent outputs |
| fwd_irq | output | N_FWD | Forwarded parent outputs, one per forward bit |
| wake_irq | output | 1 | Wakeup request |

## Verification
A corrupted enable bit shows up one clock later as a grouped or wake output that disagrees with the lines being driven, and it appears at once in an enable read-back. A status word that picks up unconnected or stale bits is visible in the next status read, and it also shows as a mismatch between the forward outputs and the status word on the following edge. A forward gate wired to the wrong place shows up within one clock, either as a forward output that ignores its line or as a grouped output or wake output that reacts to a forwarded line.

// File: rtl/irq_l2_pkg.sv
package irq_l2_pkg;

  localparam int WORD_W = 32;

  // number of set bits in a word
  function automatic int popcount32(input logic [WORD_W-1:0] v);
    int n;
    n = 0;
    for (int i = 0; i < WORD_W; i++) n += int'(v[i]);
    return n;
  endfunction

  // bit index of the n-th set bit, counted upward from bit 0
  function automatic int nth_set_bit(input logic [WORD_W-1:0] v, input int n);
    int seen;
    int idx;
    seen = 0;
    idx  = 0;
    for (int i = 0; i < WORD_W; i++) begin
      if (v[i]) begin
        if (seen == n) idx = i;
        seen++;
      end
    end
    return idx;
  endfunction

endpackage

// File: rtl/irq_l2_regs.sv
module irq_l2_regs
  import irq_l2_pkg::*;
#(
  parameter int            ADDR_W    = 4,
  parameter logic [31:0]   CONN_MASK = 32'h0000_0FFF,
  parameter int            EN_OFS    = 0,
  parameter int            ST_OFS    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] irq_in,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic [WORD_W-1:0] pend_o,
  output logic [WORD_W-1:0] enable_q,
  output logic [WORD_W-1:0] status_q,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata
);

  localparam logic [ADDR_W-1:0] EN_A = ADDR_W'(EN_OFS);
  localparam logic [ADDR_W-1:0] ST_A = ADDR_W'(ST_OFS);

  logic              rd_req;
  logic              en_wr;
  logic [WORD_W-1:0] rd_mux;

  // only wired positions can ever be pending
  assign pend_o = irq_in & CONN_MASK;
  assign rd_req = req_valid && !req_write;
  assign en_wr  = req_valid && req_write && (req_addr == EN_A);

  always_comb begin
    if (req_addr == EN_A)      rd_mux = enable_q;
    else if (req_addr == ST_A) rd_mux = status_q;
    else                       rd_mux = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q  <= '0;
      status_q  <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      status_q  <= pend_o;
      if (en_wr) enable_q <= req_wdata & CONN_MASK;
      rsp_valid <= rd_req;
      rsp_rdata <= rd_req ? rd_mux : '0;
    end
  end

endmodule

// File: rtl/irq_l2_or.sv
module irq_l2_or
  import irq_l2_pkg::*;
#(
  parameter logic [31:0] MASK = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] src,
  input  logic [WORD_W-1:0] enable,
  output logic              irq_q
);

  logic hit;
  assign hit = |(src & enable & MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= hit;
  end

endmodule

// File: rtl/irq_l2_fwd.sv
module irq_l2_fwd
  import irq_l2_pkg::*;
#(
  parameter logic [31:0] FWD_MASK = 32'h0000_0007,
  parameter int          N_FWD    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] pend,
  output logic [N_FWD-1:0]  fwd_q
);

  for (genvar k = 0; k < N_FWD; k++) begin : g_gate
    localparam int LINE = nth_set_bit(FWD_MASK, k);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fwd_q[k] <= 1'b0;
      else        fwd_q[k] <= pend[LINE];
    end
  end

endmodule

// File: rtl/irq_l2_aggregator.sv
module irq_l2_aggregator
  import irq_l2_pkg::*;
#(
  parameter int                  ADDR_W    = 4,
  parameter int                  N_GRP     = 2,
  parameter logic [N_GRP*32-1:0] GRP_MASK  = {32'h0000_0140, 32'h0000_0EB8},
  parameter logic [31:0]         FWD_MASK  = 32'h0000_0007,
  parameter logic [31:0]         CONN_MASK = 32'h0000_0FFF,
  parameter int                  N_FWD     = popcount32(FWD_MASK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       irq_in,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic [N_GRP-1:0]  grp_irq,
  output logic [N_FWD-1:0]  fwd_irq,
  output logic              wake_irq
);

  logic [WORD_W-1:0] pend;
  logic [WORD_W-1:0] l2_pend;
  logic [WORD_W-1:0] enable_q;
  logic [WORD_W-1:0] status_q;

  irq_l2_regs #(
    .ADDR_W   (ADDR_W),
    .CONN_MASK(CONN_MASK),
    .EN_OFS   (0),
    .ST_OFS   (4)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_in   (irq_in),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .pend_o   (pend),
    .enable_q (enable_q),
    .status_q (status_q),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

  // forwarded lines are steered away from the second-level logic
  assign l2_pend = pend & ~FWD_MASK;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    irq_l2_or #(.MASK(GRP_MASK[g*32 +: 32])) u_or (
      .clk   (clk),
      .rst_n (rst_n),
      .src   (l2_pend),
      .enable(enable_q),
      .irq_q (grp_irq[g])
    );
  end

  irq_l2_or #(.MASK(32'hFFFF_FFFF)) u_wake (
    .clk   (clk),
    .rst_n (rst_n),
    .src   (l2_pend),
    .enable(enable_q),
    .irq_q (wake_irq)
  );

  irq_l2_fwd #(.FWD_MASK(FWD_MASK), .N_FWD(N_FWD)) u_fwd (
    .clk  (clk),
    .rst_n(rst_n),
    .pend (pend),
    .fwd_q(fwd_irq)
  );

endmodule

// File: rtl/irq_l2_aggregator_chk.sv
module irq_l2_aggregator_chk
  import irq_l2_pkg::*;
#(
  parameter int                  ADDR_W    = 4,
  parameter int                  N_GRP     = 2,
  parameter logic [N_GRP*32-1:0] GRP_MASK  = {32'h0000_0140, 32'h0000_0EB8},
  parameter logic [31:0]         FWD_MASK  = 32'h0000_0007,
  parameter logic [31:0]         CONN_MASK = 32'h0000_0FFF,
  parameter int                  N_FWD     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       enable_q,
  input logic [31:0]       status_q,
  input logic              rsp_valid,
  input logic [N_GRP-1:0]  grp_irq,
  input logic [N_FWD-1:0]  fwd_irq,
  input logic              wake_irq
);

  localparam logic [ADDR_W-1:0] EN_A = ADDR_W'(0);

  // R9
  unconn_status_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & ~CONN_MASK) == '0);

  // R4
  enable_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write && req_addr == EN_A) |=> $stable(enable_q));

  // R10
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid && !req_write));

  // R8
  wake_matches_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq == |(status_q & $past(enable_q) & ~FWD_MASK));

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp_chk
    // R5
    grp_matches_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grp_irq[g] == |(status_q & $past(enable_q) & GRP_MASK[g*32 +: 32] & ~FWD_MASK));
  end

  for (genvar k = 0; k < N_FWD; k++) begin : g_fwd_chk
    localparam int LINE = nth_set_bit(FWD_MASK, k);
    // R6
    fwd_tracks_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_irq[k] == status_q[LINE]);
  end

endmodule

bind irq_l2_aggregator irq_l2_aggregator_chk #(
  .ADDR_W   (ADDR_W),
  .N_GRP    (N_GRP),
  .GRP_MASK (GRP_MASK),
  .FWD_MASK (FWD_MASK),
  .CONN_MASK(CONN_MASK),
  .N_FWD    (N_FWD)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_write(req_write),
  .req_addr (req_addr),
  .enable_q (enable_q),
  .status_q (status_q),
  .rsp_valid(rsp_valid),
  .grp_irq  (grp_irq),
  .fwd_irq  (fwd_irq),
  .wake_irq (wake_irq)
);

// File: tb/irq_l2_aggregator_tb.sv
`timescale 1ns/1ps
module irq_l2_aggregator_tb;

  localparam logic [31:0] CONN = 32'h0000_0FFF;
  localparam logic [31:0] FWD  = 32'h0000_0007;
  localparam logic [31:0] M0   = 32'h0000_0EB8;
  localparam logic [31:0] M1   = 32'h0000_0140;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [1:0]  grp_irq;
  logic [2:0]  fwd_irq;
  logic        wake_irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  logic [31:0] en_model = '0;

  always #4 clk = ~clk;

  irq_l2_aggregator u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .grp_irq(grp_irq), .fwd_irq(fwd_irq), .wake_irq(wake_irq)
  );

  function automatic logic [1:0] exp_grp(logic [31:0] l, logic [31:0] e);
    logic [31:0] s;
    s = l & CONN & ~FWD & e;
    return {|(s & M1), |(s & M0)};
  endfunction

  function automatic logic exp_wake(logic [31:0] l, logic [31:0] e);
    return |(l & CONN & ~FWD & e);
  endfunction

  function automatic logic [2:0] exp_fwd(logic [31:0] l);
    return l[2:0];
  endfunction

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s got %h exp %h", req, what, got, exp);
    end
  endtask

  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_write(logic [3:0] a, logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    if (a == 4'h0) en_model = d & CONN;
  endtask

  task automatic bus_read(logic [3:0] a, output logic [31:0] d, output logic v);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
    v = rsp_valid;
  endtask

  task automatic check_outs(string req);
    chk(req, "grp_irq", 32'(grp_irq), 32'(exp_grp(irq_in, en_model)));
    chk(req, "wake_irq", 32'(wake_irq), 32'(exp_wake(irq_in, en_model)));
    chk(req, "fwd_irq", 32'(fwd_irq), 32'(exp_fwd(irq_in)));
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] d;
    logic        v;
    int unsigned seed;
    seed = $urandom(32'd4138);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "grp_irq", 32'(grp_irq), 32'h0);
    chk("R1", "wake_irq", 32'(wake_irq), 32'h0);
    chk("R1", "rsp_valid", 32'(rsp_valid), 32'h0);
    bus_read(4'h0, d, v);
    chk("R1", "enable", d, 32'h0);
    chk("R10", "rsp_valid after read", 32'(v), 32'h1);
    settle();
    chk("R10", "rsp_valid idle", 32'(rsp_valid), 32'h0);

    // R6 forward path works with enable cleared
    irq_in = 32'h0000_0002;
    settle();
    chk("R6", "fwd_irq enable=0", 32'(fwd_irq), 32'h2);
    check_outs("R6");

    // R2 full-word write, unconnected bits dropped
    bus_write(4'h0, 32'hFFFF_FFFF);
    chk("R10", "rsp_valid after write", 32'(rsp_valid), 32'h0);
    bus_read(4'h0, d, v);
    chk("R2", "enable readback", d, 32'h0000_0FFF);

    // R9 unconnected lines never assert anything
    irq_in = 32'hFFFF_F000;
    settle();
    check_outs("R9");
    chk("R9", "grp_irq zero", 32'(grp_irq), 32'h0);
    chk("R9", "wake_irq zero", 32'(wake_irq), 32'h0);
    bus_read(4'h4, d, v);
    chk("R9", "status unconnected", d, 32'h0);

    // R7 forwarded lines enabled but excluded from groups and wake
    irq_in = 32'h0000_0007;
    settle();
    chk("R7", "grp_irq", 32'(grp_irq), 32'h0);
    chk("R7", "wake_irq", 32'(wake_irq), 32'h0);
    chk("R6", "fwd_irq all", 32'(fwd_irq), 32'h7);

    // R5 group selection
    irq_in = 32'h0000_0008;
    settle();
    chk("R5", "line3 group0", 32'(grp_irq), 32'h1);
    chk("R8", "line3 wake", 32'(wake_irq), 32'h1);
    irq_in = 32'h0000_0100;
    settle();
    chk("R5", "line8 group1", 32'(grp_irq), 32'h2);
    irq_in = 32'h0000_0000;
    settle();
    chk("R5", "deassert", 32'(grp_irq), 32'h0);

    // R2 read-modify-write: clear only bit 6
    bus_read(4'h0, d, v);
    bus_write(4'h0, d & ~32'h40);
    bus_read(4'h0, d, v);
    chk("R2", "rmw clear bit6", d, 32'h0000_0FBF);
    irq_in = 32'h0000_0140;
    settle();
    chk("R2", "line6 masked, line8 live", 32'(grp_irq), 32'h2);
    irq_in = 32'h0000_0040;
    settle();
    chk("R8", "wake off for disabled line", 32'(wake_irq), 32'h0);

    // R3 status read and ignored write
    irq_in = 32'h0000_05A5;
    settle();
    bus_read(4'h4, d, v);
    chk("R3", "status", d, 32'h0000_05A5);
    bus_write(4'h4, 32'h0);
    bus_read(4'h4, d, v);
    chk("R3", "status after write", d, 32'h0000_05A5);
    bus_read(4'h0, d, v);
    chk("R3", "enable after status write", d, 32'h0000_0FBF);

    // R4 unmapped offsets
    bus_write(4'h8, 32'h0);
    bus_write(4'hC, 32'h0);
    bus_read(4'h0, d, v);
    chk("R4", "enable after unmapped write", d, 32'h0000_0FBF);
    bus_read(4'h8, d, v);
    chk("R4", "offset 8 reads", d, 32'h0);
    bus_read(4'hC, d, v);
    chk("R4", "offset C reads", d, 32'h0);

    // random mix for R5, R6, R8, R3
    for (int i = 0; i < 400; i++) begin
      if ($urandom % 4 == 0) bus_write(4'h0, $urandom);
      irq_in = $urandom;
      if ($urandom % 3 == 0) irq_in = irq_in & 32'h0000_0FFF;
      settle();
      check_outs("R5");
      if (i % 16 == 0) begin
        bus_read(4'h4, d, v);
        chk("R3", "random status", d, irq_in & CONN);
      end
    end

    summary();
  end

endmodule